// File: doc/BRIEF.md
# Frame Buffer Line Prefetch Controller

This block runs in the system clock domain. It moves video lines from an external memory controller into a dual-clock video FIFO. An external agent hands it a frame buffer base address with a one-cycle valid pulse. When the enable input is high and an address is pending, the block starts a frame. It latches the horizontal and vertical resolution and then walks through the frame buffer with a chain of read requests. Each request carries a start address and a byte count.

The first request of a frame fetches a larger group of lines so the FIFO fills before the display starts. After that, the block only requests a smaller group of lines, and only when the FIFO reports that it is below its half-empty level. Each request is held until the memory side toggles its acknowledge line. The block then waits for the memory side's completion strobe before it moves the address forward and considers the next request. Returned words go to the FIFO write port one cycle after they arrive.

Busy covers the whole frame. Done pulses once when the last line has been fetched. A frame-under-display output shows the base address of the frame being read. A base address that arrives mid-frame is queued for the following frame.

Top module: `lfc_line_fetch`

## Requirements
- R1: A base address is captured on a cycle where `base_vld_i` is high. When a frame starts, `frame_addr_o` takes that address and `busy_o` goes high.
- R2: While `rd_req_o` is high, `rd_addr_o` and `rd_bytes_o` hold steady.
- R3: `rd_req_o` stays high until `rd_ack_i` changes level. It falls on the clock edge where the change is first seen.
- R4: After the acknowledge, no new request is raised until `rd_done_i` has been seen high.
- R5: `fifo_wr_o` and `fifo_data_o` repeat `rd_valid_i` and `rd_data_i` one clock later.
- R6: The first request of a frame covers min(INIT_LINES, vertical lines) lines.
- R7: Each later request covers min(SUB_LINES, remaining lines) lines. It is raised only while `fifo_low_i` is high.
- R8: The byte count is lines × horizontal resolution × BYTES_PER_PIX. The first start address is the base. Each following start address is the previous one plus the previous byte count.
- R9: Once every line has been fetched, `done_o` is high for exactly one cycle and `busy_o` is low in that same cycle.
- R10: A base address that arrives during a frame leaves `frame_addr_o` unchanged. It is used by the next frame.
- R11: No frame starts while `en_i` is low, even when an address is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Allows a new frame to start |
| hres_i | input | RES_W | Horizontal resolution in pixels |
| vres_i | input | VRES_W | Vertical resolution in lines |
| base_addr_i | input | ADDR_W | Frame buffer base address |
| base_vld_i | input | 1 | Valid pulse for base_addr_i |
| rd_req_o | output | 1 | Read request to memory controller |
| rd_ack_i | input | 1 | Acknowledge; a change of level counts as an acknowledge |
| rd_done_i | input | 1 | Read completion strobe |
| rd_addr_o | output | ADDR_W | Start address of the request |
| rd_bytes_o | output | CNT_W | Byte count of the request |
| rd_data_i | input | DATA_W | Returned data word |
| rd_valid_i | input | 1 | Returned data valid |
| fifo_wr_o | output | 1 | FIFO write enable |
| fifo_data_o | output | DATA_W | FIFO write data |
| fifo_low_i | input | 1 | FIFO is below its half-empty threshold |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse when the frame is fully fetched |
| frame_addr_o | output | ADDR_W | Base address of the frame being read |

## Verification
The bench uses frames of 1 line, exactly INIT_LINES lines, and INIT_LINES+1 lines, together with random sizes.

- Tiny frames catch a design that skips the min() clamp. Such a design overfetches past the frame end.
- A remainder of one line catches a last request that is counted wrong.
- Holding the acknowledge at a constant high or low level catches a design that treats a level as the acknowledge; it drops the request early.
- Keeping the FIFO-low input deasserted for random stretches catches refills that ignore the threshold.
- Sending a base address mid-frame catches a design that updates the frame-under-display output too early.
- Keeping enable low afterwards catches a frame that starts by itself.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_ACK   = 2'd2,
    ST_DONE  = 2'd3
  } lfc_state_e;
endpackage

// File: rtl/lfc_toggle_det.sv
module lfc_toggle_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic tgl_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign tgl_o = lvl_i ^ lvl_q;
endmodule

// File: rtl/lfc_base_hold.sv
module lfc_base_hold #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              take_i,
  output logic              pend_o,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      addr_o <= '0;
    end else if (vld_i) begin
      // a fresh address wins over a consume in the same cycle
      pend_o <= 1'b1;
      addr_o <= addr_i;
    end else if (take_i) begin
      pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/lfc_burst_calc.sv
module lfc_burst_calc #(
  parameter int RES_W         = 12,
  parameter int VRES_W        = 11,
  parameter int CNT_W         = 16,
  parameter int BYTES_PER_PIX = 4,
  parameter int INIT_LINES    = 4,
  parameter int SUB_LINES     = 2
) (
  input  logic              first_i,
  input  logic [VRES_W-1:0] left_i,
  input  logic [RES_W-1:0]  hres_i,
  output logic [VRES_W-1:0] lines_o,
  output logic [CNT_W-1:0]  bytes_o
);
  localparam int BPP_W  = $clog2(BYTES_PER_PIX + 1);
  localparam int PROD_W = VRES_W + RES_W + BPP_W;
  localparam logic [VRES_W-1:0] INIT_L = VRES_W'(INIT_LINES);
  localparam logic [VRES_W-1:0] SUB_L  = VRES_W'(SUB_LINES);

  logic [VRES_W-1:0] grp;
  logic [PROD_W-1:0] prod;

  always_comb begin
    grp     = first_i ? INIT_L : SUB_L;
    lines_o = (left_i < grp) ? left_i : grp;
    prod    = PROD_W'(lines_o) * PROD_W'(hres_i) * PROD_W'(BYTES_PER_PIX);
    bytes_o = prod[CNT_W-1:0];
  end
endmodule

// File: rtl/lfc_line_fetch.sv
module lfc_line_fetch
  import lfc_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int CNT_W         = 16,
  parameter int RES_W         = 12,
  parameter int VRES_W        = 11,
  parameter int DATA_W        = 24,
  parameter int BYTES_PER_PIX = 4,
  parameter int INIT_LINES    = 4,
  parameter int SUB_LINES     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [RES_W-1:0]  hres_i,
  input  logic [VRES_W-1:0] vres_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic              base_vld_i,
  output logic              rd_req_o,
  input  logic              rd_ack_i,
  input  logic              rd_done_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [CNT_W-1:0]  rd_bytes_o,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              rd_valid_i,
  output logic              fifo_wr_o,
  output logic [DATA_W-1:0] fifo_data_o,
  input  logic              fifo_low_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] frame_addr_o
);
  lfc_state_e        state_q;
  logic              ack_tgl;
  logic              pend;
  logic [ADDR_W-1:0] pend_addr;
  logic              take;
  logic              first_q;
  logic [VRES_W-1:0] left_q;
  logic [RES_W-1:0]  hres_q;
  logic [ADDR_W-1:0] cur_addr_q;
  logic [VRES_W-1:0] req_lines_q;
  logic [VRES_W-1:0] calc_lines;
  logic [CNT_W-1:0]  calc_bytes;

  assign take = (state_q == ST_IDLE) && en_i && pend;

  lfc_toggle_det i_ack_det (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (rd_ack_i),
    .tgl_o (ack_tgl)
  );

  lfc_base_hold #(.ADDR_W(ADDR_W)) i_base_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (base_vld_i),
    .addr_i(base_addr_i),
    .take_i(take),
    .pend_o(pend),
    .addr_o(pend_addr)
  );

  lfc_burst_calc #(
    .RES_W        (RES_W),
    .VRES_W       (VRES_W),
    .CNT_W        (CNT_W),
    .BYTES_PER_PIX(BYTES_PER_PIX),
    .INIT_LINES   (INIT_LINES),
    .SUB_LINES    (SUB_LINES)
  ) i_calc (
    .first_i(first_q),
    .left_i (left_q),
    .hres_i (hres_q),
    .lines_o(calc_lines),
    .bytes_o(calc_bytes)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      first_q      <= 1'b0;
      left_q       <= '0;
      hres_q       <= '0;
      cur_addr_q   <= '0;
      req_lines_q  <= '0;
      rd_req_o     <= 1'b0;
      rd_addr_o    <= '0;
      rd_bytes_o   <= '0;
      busy_o       <= 1'b0;
      done_o       <= 1'b0;
      frame_addr_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (take) begin
            frame_addr_o <= pend_addr;
            cur_addr_q   <= pend_addr;
            left_q       <= vres_i;
            hres_q       <= hres_i;
            first_q      <= 1'b1;
            busy_o       <= 1'b1;
            state_q      <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (left_q == '0) begin
            done_o  <= 1'b1;
            busy_o  <= 1'b0;
            state_q <= ST_IDLE;
          end else if (first_q || fifo_low_i) begin
            rd_req_o    <= 1'b1;
            rd_addr_o   <= cur_addr_q;
            rd_bytes_o  <= calc_bytes;
            req_lines_q <= calc_lines;
            state_q     <= ST_ACK;
          end
        end
        ST_ACK: begin
          if (ack_tgl) begin
            rd_req_o <= 1'b0;
            state_q  <= ST_DONE;
          end
        end
        ST_DONE: begin
          if (rd_done_i) begin
            cur_addr_q <= cur_addr_q + ADDR_W'(rd_bytes_o);
            left_q     <= left_q - req_lines_q;
            first_q    <= 1'b0;
            state_q    <= ST_ISSUE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fifo_wr_o   <= 1'b0;
      fifo_data_o <= '0;
    end else begin
      fifo_wr_o   <= rd_valid_i;
      fifo_data_o <= rd_data_i;
    end
  end
endmodule

// File: rtl/lfc_line_fetch_chk.sv
module lfc_line_fetch_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_req_o,
  input logic              rd_ack_i,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic [CNT_W-1:0]  rd_bytes_o,
  input logic              rd_valid_i,
  input logic              fifo_wr_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] frame_addr_o
);
  p_req_fields_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && $past(rd_req_o) |-> $stable(rd_addr_o) && $stable(rd_bytes_o));

  p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && $stable(rd_ack_i) |=> rd_req_o);

  p_req_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !$stable(rd_ack_i) |=> !rd_req_o);

  p_fifo_wr_on_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i |=> fifo_wr_o);

  p_fifo_wr_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_i |=> !fifo_wr_o);

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_not_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_req_in_frame_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> busy_o);

  p_frame_addr_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(frame_addr_o));
endmodule

bind lfc_line_fetch lfc_line_fetch_chk #(
  .ADDR_W(ADDR_W),
  .CNT_W (CNT_W)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_req_o    (rd_req_o),
  .rd_ack_i    (rd_ack_i),
  .rd_addr_o   (rd_addr_o),
  .rd_bytes_o  (rd_bytes_o),
  .rd_valid_i  (rd_valid_i),
  .fifo_wr_o   (fifo_wr_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .frame_addr_o(frame_addr_o)
);

// File: tb/test_lfc_line_fetch.sv
module test_lfc_line_fetch;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 16;
  localparam int RES_W  = 12;
  localparam int VRES_W = 11;
  localparam int DATA_W = 24;
  localparam int BPP    = 4;
  localparam int INIT_L = 4;
  localparam int SUB_L  = 2;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              en_i = 1'b0;
  logic [RES_W-1:0]  hres_i = '0;
  logic [VRES_W-1:0] vres_i = '0;
  logic [ADDR_W-1:0] base_addr_i = '0;
  logic              base_vld_i = 1'b0;
  logic              rd_req_o;
  logic              rd_ack_i = 1'b0;
  logic              rd_done_i = 1'b0;
  logic [ADDR_W-1:0] rd_addr_o;
  logic [CNT_W-1:0]  rd_bytes_o;
  logic [DATA_W-1:0] rd_data_i = '0;
  logic              rd_valid_i = 1'b0;
  logic              fifo_wr_o;
  logic [DATA_W-1:0] fifo_data_o;
  logic              fifo_low_i = 1'b0;
  logic              busy_o;
  logic              done_o;
  logic [ADDR_W-1:0] frame_addr_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int unsigned seed = 32'd7;

  always #10 clk = ~clk;

  lfc_line_fetch #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .RES_W(RES_W), .VRES_W(VRES_W),
    .DATA_W(DATA_W), .BYTES_PER_PIX(BPP), .INIT_LINES(INIT_L), .SUB_LINES(SUB_L)
  ) i_lfc_line_fetch (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .hres_i(hres_i), .vres_i(vres_i),
    .base_addr_i(base_addr_i), .base_vld_i(base_vld_i),
    .rd_req_o(rd_req_o), .rd_ack_i(rd_ack_i), .rd_done_i(rd_done_i),
    .rd_addr_o(rd_addr_o), .rd_bytes_o(rd_bytes_o),
    .rd_data_i(rd_data_i), .rd_valid_i(rd_valid_i),
    .fifo_wr_o(fifo_wr_o), .fifo_data_o(fifo_data_o), .fifo_low_i(fifo_low_i),
    .busy_o(busy_o), .done_o(done_o), .frame_addr_o(frame_addr_o)
  );

  task automatic summary_and_end();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      summary_and_end();
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_lines(input bit first, input int left);
    int g = first ? INIT_L : SUB_L;
    return (left < g) ? left : g;
  endfunction

  function automatic int exp_bytes(input int lines, input int hres);
    return lines * hres * BPP;
  endfunction

  task automatic wait_req();
    for (int i = 0; i < 200; i++) begin
      if (rd_req_o) return;
      @(negedge clk);
    end
    chk(1'b0, "R7 request timeout", rd_req_o, 1);
  endtask

  task automatic pulse_base(input logic [ADDR_W-1:0] a);
    base_addr_i = a;
    base_vld_i  = 1'b1;
    @(negedge clk);
    base_vld_i  = 1'b0;
  endtask

  // one complete frame; mid_base != 0 queues an address during the frame
  task automatic run_frame(input logic [ADDR_W-1:0] base, input bit send_base,
                           input int hres, input int vres,
                           input logic [ADDR_W-1:0] mid_base);
    int left = vres;
    logic [ADDR_W-1:0] addr = base;
    bit first = 1'b1;
    bit mid_sent = 1'b0;
    hres_i = RES_W'(hres);
    vres_i = VRES_W'(vres);
    @(negedge clk);
    if (send_base) pulse_base(base);
    en_i = 1'b1;
    while (left > 0) begin
      int n = exp_lines(first, left);
      if (!first) begin
        int d = 1 + int'($urandom(seed) % 6);
        for (int i = 0; i < d; i++) @(negedge clk);
        chk(rd_req_o == 1'b0, "R7 no refill while FIFO not low", rd_req_o, 0);
        fifo_low_i = 1'b1;
      end
      wait_req();
      fifo_low_i = 1'b0;
      if (first) begin
        chk(frame_addr_o == base, "R1 frame address", frame_addr_o, base);
        chk(busy_o == 1'b1, "R1 busy in frame", busy_o, 1);
        chk(rd_bytes_o == CNT_W'(exp_bytes(n, hres)), "R6 first burst bytes",
            rd_bytes_o, exp_bytes(n, hres));
      end else begin
        chk(rd_bytes_o == CNT_W'(exp_bytes(n, hres)), "R7 R8 refill bytes",
            rd_bytes_o, exp_bytes(n, hres));
      end
      chk(rd_addr_o == addr, "R8 start address", rd_addr_o, addr);
      if (!mid_sent && mid_base != '0) begin
        pulse_base(mid_base);
        mid_sent = 1'b1;
        chk(frame_addr_o == base, "R10 frame address held", frame_addr_o, base);
      end
      // ack held at constant level: request must stay
      for (int i = 0; i < int'($urandom(seed) % 4); i++) begin
        @(negedge clk);
        chk(rd_req_o == 1'b1, "R3 request held", rd_req_o, 1);
        chk(rd_addr_o == addr, "R2 address stable", rd_addr_o, addr);
      end
      rd_ack_i = ~rd_ack_i;
      @(negedge clk);
      chk(rd_req_o == 1'b0, "R3 request drop after toggle", rd_req_o, 0);
      // data returns while waiting for done; FIFO low asserted to tempt a request
      fifo_low_i = 1'b1;
      for (int i = 0; i < 3; i++) begin
        logic v = 1'($urandom(seed));
        logic [DATA_W-1:0] dv = DATA_W'($urandom(seed));
        rd_valid_i = v;
        rd_data_i  = dv;
        @(negedge clk);
        chk(fifo_wr_o == v && (!v || fifo_data_o == dv), "R5 FIFO write",
            {fifo_wr_o, fifo_data_o}, {v, dv});
        chk(rd_req_o == 1'b0, "R4 no request before done", rd_req_o, 0);
      end
      rd_valid_i = 1'b0;
      fifo_low_i = 1'b0;
      rd_done_i  = 1'b1;
      @(negedge clk);
      rd_done_i  = 1'b0;
      addr  = addr + ADDR_W'(exp_bytes(n, hres));
      left  = left - n;
      first = 1'b0;
    end
    @(negedge clk);
    chk(done_o == 1'b1, "R9 done pulse", done_o, 1);
    chk(busy_o == 1'b0, "R9 busy low with done", busy_o, 0);
    en_i = 1'b0;
    @(negedge clk);
    chk(done_o == 1'b0, "R9 done one cycle", done_o, 0);
    chk(frame_addr_o == base, "R10 frame address kept to end", frame_addr_o, base);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(rd_req_o == 1'b0 && busy_o == 1'b0 && done_o == 1'b0 && fifo_wr_o == 1'b0,
        "R1 reset state", {rd_req_o, busy_o, done_o, fifo_wr_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    // directed: 1 line, exactly INIT lines, INIT+1 lines
    run_frame(32'h0000_1000, 1'b1, 64, 1, '0);
    run_frame(32'h0002_0000, 1'b1, 100, INIT_L, '0);
    run_frame(32'h0004_0000, 1'b1, 32, INIT_L + 1, 32'h0009_0000);
    // R11: queued address, enable low, nothing starts
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(busy_o == 1'b0 && rd_req_o == 1'b0, "R11 no start while disabled",
          {busy_o, rd_req_o}, 0);
    end
    run_frame(32'h0009_0000, 1'b0, 48, 3, '0);
    for (int f = 0; f < 8; f++) begin
      logic [ADDR_W-1:0] b = {$urandom(seed) % 32'h0100_0000} & 32'hFFFF_FF00;
      int h = 16 * (1 + int'($urandom(seed) % 10));
      int v = 1 + int'($urandom(seed) % 11);
      run_frame(b | 32'h100, 1'b1, h, v, '0);
    end
    summary_and_end();
  end
endmodule